// File: doc/BRIEF.md
# DMA Burst Preemption Arbiter

This block decides who owns the external bus when a DMA burst competes with two other requesters. One is a memory refresh engine and the other is an outside master that wants the bus. A small priority code, held in a register inside the block, sets which of the two may cut into a burst that is already running. When a requester gets the bus, the block raises a pause signal toward the DMA engine.

A requester may only take over from a burst at a beat boundary, which the DMA engine flags. When no burst is running, the priority code does not restrict either requester. Requests are levels that stay high until served. A grant stays with its requester for as long as the request is held. A held-off request waits, and it is served as soon as the burst ends.

There is no data path through the block, so there is no valid/ready stream. Every pin is a plain control or status level, sampled on the rising clock edge.

Top module: `dma_preempt_arbiter`

## Requirements
- R1: After reset both grants, `dma_hold` and `config_error` are low, and the stored priority code is 00.
- R2: While `dma_burst_active` is low and no grant is held, a pending request is granted at the next rising edge, whatever the priority code.
- R3: With code 00 stored, a request seen during a burst at a beat boundary is granted at that edge, for either requester.
- R4: With code 01 stored, `refresh_req` can win during a burst but `bus_req` is never granted while the burst lasts.
- R5: With code 10 stored, neither request is granted while `dma_burst_active` is high.
- R6: Writing code 11 through `cfg_we`/`cfg_prio` makes the block act as if 10 were stored and sets `config_error`. The flag then stays high until reset, even after a valid code is written. A write takes effect from the edge after the one that stores it.
- R7: A request held off by the code is granted at the first rising edge that samples `dma_burst_active` low.
- R8: When both requests are pending and both are allowed at the same edge, the refresh side is granted.
- R9: During a burst, no grant starts at an edge where `beat_boundary` is low.
- R10: A grant holds while its request stays high and drops at the first edge that samples the request low. No new grant starts at that same edge, and at most one grant is high at a time.
- R11: `dma_hold` is high exactly when either grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Store `cfg_prio` into the priority register |
| cfg_prio | input | 2 | Priority code: 00 both may preempt, 01 refresh only, 10 none, 11 reserved |
| dma_burst_active | input | 1 | A DMA burst is in progress |
| beat_boundary | input | 1 | The current cycle ends a burst beat, so a handover is allowed |
| refresh_req | input | 1 | Refresh request level |
| bus_req | input | 1 | External bus-mastership request level |
| refresh_grant | output | 1 | Bus given to the refresh engine |
| bus_grant | output | 1 | Bus given to the external master |
| dma_hold | output | 1 | Pause the DMA burst |
| config_error | output | 1 | Sticky flag: the reserved code was written |

## Verification
The assertions check these properties on every cycle:
- a grant keeps going while its request is held,
- releasing a grant leaves one empty cycle,
- no grant starts mid-beat,
- code 10 blocks everything during a burst,
- code 01 blocks the external master during a burst,
- the error flag is sticky,
- refresh wins a tie.

Other behaviour can only be shown by the bench's scenarios:
- a held-off request is served right after the burst ends,
- a write takes effect one edge late,
- the reserved code behaves like code 10,
- the priority code is ignored outside a burst.

The bench's reference model follows these over long random runs.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W = 2;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_ALL      = 2'b00,
    PRIO_REF_ONLY = 2'b01,
    PRIO_NONE     = 2'b10,
    PRIO_RSVD     = 2'b11
  } prio_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_REF  = 2'b01,
    OWN_BUS  = 2'b10
  } owner_e;
endpackage

// File: rtl/dma_arb_cfg.sv
module dma_arb_cfg
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PRIO_W-1:0] cfg_prio,
  output prio_e             mode_eff,
  output logic              config_error
);
  prio_e prio_q;
  logic  err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= PRIO_ALL;
      err_q  <= 1'b0;
    end else if (cfg_we) begin
      prio_q <= prio_e'(cfg_prio);
      if (prio_e'(cfg_prio) == PRIO_RSVD) err_q <= 1'b1;
    end
  end

  // reserved encoding folds onto the most restrictive legal one
  assign mode_eff     = (prio_q == PRIO_RSVD) ? PRIO_NONE : prio_q;
  assign config_error = err_q;

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);

  // R6
  rsvd_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_prio == 2'b11) |=> (config_error && mode_eff == PRIO_NONE));
endmodule

// File: rtl/dma_arb_gate.sv
module dma_arb_gate
  import dma_arb_pkg::*;
(
  input  logic  dma_active,
  input  logic  beat_boundary,
  input  prio_e mode,
  output logic  allow_ref,
  output logic  allow_bus
);
  logic handover_ok;
  logic ref_ok_in_burst;
  logic bus_ok_in_burst;

  assign handover_ok     = !dma_active || beat_boundary;
  assign ref_ok_in_burst = (mode == PRIO_ALL) || (mode == PRIO_REF_ONLY);
  assign bus_ok_in_burst = (mode == PRIO_ALL);

  assign allow_ref = handover_ok && (!dma_active || ref_ok_in_burst);
  assign allow_bus = handover_ok && (!dma_active || bus_ok_in_burst);
endmodule

// File: rtl/dma_arb_grant.sv
module dma_arb_grant
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_req,
  input  logic bus_req,
  input  logic allow_ref,
  input  logic allow_bus,
  output logic refresh_grant,
  output logic bus_grant
);
  owner_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    case (own_q)
      OWN_REF: if (!refresh_req) own_d = OWN_NONE;
      OWN_BUS: if (!bus_req)     own_d = OWN_NONE;
      default: begin
        if (refresh_req && allow_ref)  own_d = OWN_REF;
        else if (bus_req && allow_bus) own_d = OWN_BUS;
        else                           own_d = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign refresh_grant = (own_q == OWN_REF);
  assign bus_grant     = (own_q == OWN_BUS);

  // R10
  ref_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_grant && refresh_req) |=> refresh_grant);

  // R10
  bus_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req) |=> bus_grant);

  // R10
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((refresh_grant && !refresh_req) || (bus_grant && !bus_req))
      |=> (!refresh_grant && !bus_grant));

  // R8
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_grant && !bus_grant && refresh_req && allow_ref && bus_req && allow_bus)
      |=> (refresh_grant && !bus_grant));
endmodule

// File: rtl/dma_preempt_arbiter.sv
module dma_preempt_arbiter
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              dma_burst_active,
  input  logic              beat_boundary,
  input  logic              refresh_req,
  input  logic              bus_req,
  output logic              refresh_grant,
  output logic              bus_grant,
  output logic              dma_hold,
  output logic              config_error
);
  prio_e mode_eff;
  logic  allow_ref, allow_bus;

  dma_arb_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_prio     (cfg_prio),
    .mode_eff     (mode_eff),
    .config_error (config_error)
  );

  dma_arb_gate u_gate (
    .dma_active    (dma_burst_active),
    .beat_boundary (beat_boundary),
    .mode          (mode_eff),
    .allow_ref     (allow_ref),
    .allow_bus     (allow_bus)
  );

  dma_arb_grant u_grant (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh_req   (refresh_req),
    .bus_req       (bus_req),
    .allow_ref     (allow_ref),
    .allow_bus     (allow_bus),
    .refresh_grant (refresh_grant),
    .bus_grant     (bus_grant)
  );

  assign dma_hold = refresh_grant | bus_grant;

  // R9
  mid_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_hold && dma_burst_active && !beat_boundary) |=> !dma_hold);

  // R5
  hold_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_hold && dma_burst_active && mode_eff == PRIO_NONE) |=> !dma_hold);

  // R4
  bus_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && dma_burst_active && mode_eff != PRIO_ALL) |=> !bus_grant);

  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refresh_grant, bus_grant}));
endmodule

// File: tb/dma_preempt_arbiter_test.sv
`timescale 1ns/1ps
module dma_preempt_arbiter_test;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_prio = 2'b00;
  logic dma = 1'b0, bnd = 1'b0, rreq = 1'b0, breq = 1'b0;
  logic refresh_grant, bus_grant, dma_hold, config_error;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic [1:0] m_code;
  logic m_err, m_rg, m_bg;

  always #(CLK_P/2) clk = ~clk;

  dma_preempt_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prio(cfg_prio),
    .dma_burst_active(dma), .beat_boundary(bnd),
    .refresh_req(rreq), .bus_req(breq),
    .refresh_grant(refresh_grant), .bus_grant(bus_grant),
    .dma_hold(dma_hold), .config_error(config_error)
  );

  function automatic logic allow_ref_f(logic [1:0] code, logic act, logic b);
    logic [1:0] c = (code == 2'b11) ? 2'b10 : code;
    if (!act) return 1'b1;
    return b && (c != 2'b10);
  endfunction

  function automatic logic allow_bus_f(logic [1:0] code, logic act, logic b);
    logic [1:0] c = (code == 2'b11) ? 2'b10 : code;
    if (!act) return 1'b1;
    return b && (c == 2'b00);
  endfunction

  task automatic model_step();
    if (m_rg)      m_rg = rreq;
    else if (m_bg) m_bg = breq;
    else if (rreq && allow_ref_f(m_code, dma, bnd)) m_rg = 1'b1;
    else if (breq && allow_bus_f(m_code, dma, bnd)) m_bg = 1'b1;
    if (cfg_we) begin
      m_code = cfg_prio;
      if (cfg_prio == 2'b11) m_err = 1'b1;
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " refresh_grant"}, refresh_grant, m_rg);
    chk({tag, " bus_grant"}, bus_grant, m_bg);
    chk({"R11 ", tag, " dma_hold"}, dma_hold, m_rg | m_bg);
    chk({tag, " config_error"}, config_error, m_err);
  endtask

  // one clock: model follows the edge, outputs sampled at the falling edge
  task automatic cyc(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      model_step();
      @(negedge clk);
      compare(tag);
      cfg_we = 1'b0;
    end
  endtask

  task automatic wr(logic [1:0] code);
    cfg_we = 1'b1; cfg_prio = code;
    cyc("R6 write");
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_code = 2'b00; m_err = 1'b0; m_rg = 1'b0; m_bg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset refresh_grant", refresh_grant, 1'b0);
    chk("R1 reset bus_grant", bus_grant, 1'b0);
    chk("R1 reset dma_hold", dma_hold, 1'b0);
    chk("R1 reset config_error", config_error, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: code ignored outside a burst
    wr(2'b10);
    breq = 1'b1; cyc("R2 idle grant");
    chk("R2 bus granted with code 10 idle", bus_grant, 1'b1);
    cyc("R10 keep", 2);
    breq = 1'b0; cyc("R10 release");
    chk("R10 released", bus_grant, 1'b0);

    // R5 then R7 and R8
    dma = 1'b1; bnd = 1'b1; rreq = 1'b1; breq = 1'b1;
    cyc("R5 hold all", 3);
    chk("R5 no grant in burst", dma_hold, 1'b0);
    dma = 1'b0; cyc("R7 burst end");
    chk("R7 refresh served after burst", refresh_grant, 1'b1);
    chk("R8 refresh wins tie", bus_grant, 1'b0);
    rreq = 1'b0; cyc("R10 gap");
    chk("R10 one empty cycle", dma_hold, 1'b0);
    cyc("R7 bus next");
    chk("R7 bus served after refresh", bus_grant, 1'b1);
    breq = 1'b0; cyc("R10 release");

    // R4: refresh only
    wr(2'b01);
    dma = 1'b1; bnd = 1'b1; breq = 1'b1;
    cyc("R4 bus blocked", 3);
    chk("R4 bus not granted", bus_grant, 1'b0);
    rreq = 1'b1; cyc("R4 refresh allowed");
    chk("R4 refresh granted", refresh_grant, 1'b1);
    rreq = 1'b0; cyc("R4 release", 2);
    chk("R4 bus still blocked", bus_grant, 1'b0);
    breq = 1'b0; cyc("R4 drop");

    // R9 and R3: beat boundary
    wr(2'b00);
    bnd = 1'b0; breq = 1'b1;
    cyc("R9 mid beat", 3);
    chk("R9 no grant mid beat", bus_grant, 1'b0);
    bnd = 1'b1; cyc("R3 boundary");
    chk("R3 bus granted at boundary", bus_grant, 1'b1);
    breq = 1'b0; cyc("R3 release");
    rreq = 1'b1; cyc("R3 refresh");
    chk("R3 refresh granted in burst", refresh_grant, 1'b1);
    rreq = 1'b0; cyc("R3 release");

    // R6: reserved code
    wr(2'b11);
    chk("R6 error set", config_error, 1'b1);
    rreq = 1'b1; cyc("R6 acts as 10", 3);
    chk("R6 refresh held off", refresh_grant, 1'b0);
    rreq = 1'b0;
    wr(2'b00);
    cyc("R6 sticky", 2);
    chk("R6 error stays", config_error, 1'b1);

    // constrained random against the reference model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) dma = ~dma;
      bnd = $urandom_range(1);
      if (rreq) begin if ($urandom_range(3) == 0) rreq = 1'b0; end
      else if ($urandom_range(2) == 0) rreq = 1'b1;
      if (breq) begin if ($urandom_range(3) == 0) breq = 1'b0; end
      else if ($urandom_range(2) == 0) breq = 1'b1;
      if ($urandom_range(15) == 0) begin
        cfg_we = 1'b1;
        cfg_prio = ($urandom_range(9) == 0) ? 2'b11 : 2'($urandom_range(2));
      end
      cyc("RND");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule